// File: doc/BRIEF.md
# Multi-Rate Hit Trigger Receiver

This block watches the combined uplink bus of several front-end readout chips and raises a one-cycle trigger whenever any enabled chip carries a set bit in its aligned word for that clock. It also keeps one free-running hit counter per chip. A shared rate select sets the number of bits each chip delivers per clock: 8, 16 or 32. Chip `i` then occupies bits `[i*W +: W]` of the bus, where `W` is that width.

Before the hit test, each chip's word passes through a bit-slip aligner. The aligner keeps the word from the previous clock and takes a `W`-bit window out of the previous and current words, set by a per-chip slip amount. An enable mask decides which chips may produce triggers and counts. The flashing-bit cleaning and the policy that drives the enables are handled upstream.

Top module: `hit_trigger_rx`

## Requirements
- R1: The rate select picks the chunk width W: code 0 gives 8 bits, code 1 gives 16, code 2 gives 32, and the unused code 3 behaves as code 0. Chip i reads bits [i*W +: W] of the data bus.
- R2: With slip amount s, the aligned word is bits [2W-1-s : W-s] of {current word, previous word}. With s = 0 the aligned word is the current word, and with s > 0 its low s bits are the top s bits of the previous clock's word for that chip.
- R3: Only the slip amount modulo W is used. At 8-bit width, amounts 1 and 9 align the same way.
- R4: A chip whose enable bit is 0 neither causes a trigger nor changes its counter, whatever its data.
- R5: The trigger output is registered. It is high in the clock after a cycle in which at least one enabled chip has a nonzero aligned word, and low after a cycle with none.
- R6: Hits on back-to-back cycles produce a trigger on each of those cycles, with no gap and no merging.
- R7: A chip's counter increases by exactly one in the clock after each cycle in which that chip is enabled and has a nonzero aligned word. Otherwise it holds.
- R8: Counters are CNT_W bits wide and wrap to zero on overflow.
- R9: Synchronous active-high reset clears the trigger, every counter and every slip history word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | N_CHIPS*32 | Uplink bus, chip i at [i*W +: W] |
| slip_i | input | N_CHIPS*5 | Per-chip slip amount, chip i at [i*5 +: 5] |
| en_i | input | N_CHIPS | Per-chip trigger and count enable |
| rate_sel_i | input | 2 | Rate code selecting W = 8, 16 or 32 |
| trig_o | output | 1 | One-cycle trigger pulse |
| cnt_o | output | N_CHIPS*CNT_W | Per-chip hit counters, chip i at [i*CNT_W +: CNT_W] |

## Verification
A corrupted slip history word shows up one clock later, because it changes the aligned window. Such a fault appears as a missing or spurious trigger together with a counter that steps when it should not, or fails to step when it should. The bench mirrors the history for all three widths and compares the trigger and every counter on each clock, so this kind of error shows up within a cycle or two. A counter that wraps early or late only becomes visible at the overflow point, so the bench narrows the counters and drives one chip past the wrap.

// File: rtl/hitrx_pkg.sv
package hitrx_pkg;

    localparam int MAX_W     = 32;
    localparam int NUM_RATES = 3;
    localparam int SLIP_W    = $clog2(MAX_W);

    typedef enum logic [1:0] {
        RATE_320  = 2'd0,
        RATE_640  = 2'd1,
        RATE_1280 = 2'd2,
        RATE_RSVD = 2'd3
    } rate_e;

    function automatic int chunk_width(input int r);
        return 8 << r;
    endfunction

endpackage

// File: rtl/hitrx_slip.sv
module hitrx_slip
    import hitrx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [W-1:0]      word_i,
    input  logic [SLIP_W-1:0] amt_i,
    output logic [W-1:0]      word_o
);
    logic [W-1:0]   prev_q;
    logic [2*W-1:0] cat;
    int unsigned    shamt;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= word_i;
    end

    always_comb begin
        cat    = {word_i, prev_q};
        shamt  = W - (int'(amt_i) % W);
        word_o = W'(cat >> shamt);
    end
endmodule

// File: rtl/hitrx_counter.sv
module hitrx_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)      cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
    end
endmodule

// File: rtl/hitrx_lane.sv
module hitrx_lane
    import hitrx_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_RATES-1:0] rate_hit_i,
    input  rate_e                rate_i,
    input  logic                 en_i,
    output logic                 hit_o,
    output logic [CNT_W-1:0]     cnt_o
);
    logic raw_hit;

    always_comb begin
        unique case (rate_i)
            RATE_640:  raw_hit = rate_hit_i[1];
            RATE_1280: raw_hit = rate_hit_i[2];
            default:   raw_hit = rate_hit_i[0];
        endcase
        hit_o = raw_hit & en_i;
    end

    hitrx_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .inc_i (hit_o),
        .cnt_o (cnt_o)
    );
endmodule

// File: rtl/hit_trigger_rx.sv
module hit_trigger_rx
    import hitrx_pkg::*;
#(
    parameter int N_CHIPS = 28,
    parameter int CNT_W   = 32
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [N_CHIPS*MAX_W-1:0]   data_i,
    input  logic [N_CHIPS*SLIP_W-1:0]  slip_i,
    input  logic [N_CHIPS-1:0]         en_i,
    input  logic [1:0]                 rate_sel_i,
    output logic                       trig_o,
    output logic [N_CHIPS*CNT_W-1:0]   cnt_o
);
    rate_e              rate;
    logic [N_CHIPS-1:0] hit_vec;

    assign rate = rate_e'(rate_sel_i);

    for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
        logic [NUM_RATES-1:0] rate_hit;

        for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
            localparam int W = chunk_width(r);
            logic [W-1:0] aligned;

            hitrx_slip #(.W(W)) u_slip (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .word_i (data_i[c*W +: W]),
                .amt_i  (slip_i[c*SLIP_W +: SLIP_W]),
                .word_o (aligned)
            );
            assign rate_hit[r] = |aligned;
        end

        hitrx_lane #(.CNT_W(CNT_W)) u_lane (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .rate_hit_i (rate_hit),
            .rate_i     (rate),
            .en_i       (en_i[c]),
            .hit_o      (hit_vec[c]),
            .cnt_o      (cnt_o[c*CNT_W +: CNT_W])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) trig_o <= 1'b0;
        else       trig_o <= |hit_vec;
    end
endmodule

// File: rtl/hitrx_checker.sv
module hitrx_checker #(
    parameter int N_CHIPS = 28,
    parameter int CNT_W   = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_CHIPS-1:0]       en,
    input logic                     trig,
    input logic [N_CHIPS*CNT_W-1:0] cnt
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!trig && cnt == '0)); // R9

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> !trig); // R4

    AST_TRIG_WITH_COUNT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (trig == (cnt != $past(cnt)))); // R5

    for (genvar i = 0; i < N_CHIPS; i++) begin : g_chk
        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (CNT_W'(cnt[i*CNT_W +: CNT_W] - $past(cnt[i*CNT_W +: CNT_W])) <= CNT_W'(1))); // R7

        AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(en[i])) |-> $stable(cnt[i*CNT_W +: CNT_W])); // R4
    end
endmodule

bind hit_trigger_rx hitrx_checker #(.N_CHIPS(N_CHIPS), .CNT_W(CNT_W)) u_hitrx_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .en   (en_i),
    .trig (trig_o),
    .cnt  (cnt_o)
);

// File: tb/test_hit_trigger_rx.sv
module test_hit_trigger_rx;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 6;
    localparam int CW = 8;
    localparam int SW = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*32-1:0] data = '0;
    logic [N*SW-1:0] slip = '0;
    logic [N-1:0]    en = '0;
    logic [1:0]      rate = 2'd0;
    logic            trig;
    logic [N*CW-1:0] cnt;

    int total = 0;
    int bad = 0;

    logic [31:0] prv [3][N];
    int          mcnt [N];

    hit_trigger_rx #(.N_CHIPS(N), .CNT_W(CW)) i_hit_trigger_rx (
        .clk_i (clk), .rst_i (rst), .data_i (data), .slip_i (slip),
        .en_i (en), .rate_sel_i (rate), .trig_o (trig), .cnt_o (cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int width_of(input logic [1:0] code);
        return (code == 2'd1) ? 16 : (code == 2'd2) ? 32 : 8;
    endfunction

    function automatic logic [31:0] wmask(input int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic logic [31:0] chip_word(input logic [N*32-1:0] d, input int c, input int w);
        return 32'(d >> (c*w)) & wmask(w);
    endfunction

    function automatic logic [31:0] align(input logic [31:0] cur, input logic [31:0] p,
                                          input int s, input int w);
        logic [63:0] cat;
        cat = ({32'b0, cur & wmask(w)} << w) | {32'b0, p & wmask(w)};
        cat = cat >> (w - (s % w));
        return cat[31:0] & wmask(w);
    endfunction

    task automatic model_reset();
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < N; c++) prv[r][c] = '0;
        for (int c = 0; c < N; c++) mcnt[c] = 0;
    endtask

    task automatic chk(input string req, input logic [N*CW-1:0] act_c, input logic act_t,
                       input logic [N*CW-1:0] exp_c, input logic exp_t);
        total++;
        if (act_t !== exp_t || act_c !== exp_c) begin
            bad++;
            $display("FAIL %s trig=%0b/%0b cnt=%h expected trig=%0b cnt=%h",
                     req, act_t, exp_t, act_c, exp_t, exp_c);
        end
    endtask

    // One clock: inputs are already applied, outputs checked at the next falling edge.
    task automatic step(input string req);
        logic            et;
        logic [N*CW-1:0] ec;
        int              w;
        w  = width_of(rate);
        et = 1'b0;
        for (int c = 0; c < N; c++) begin
            logic [31:0] a;
            a = align(chip_word(data, c, w), prv[w == 8 ? 0 : w == 16 ? 1 : 2][c],
                      int'(slip[c*SW +: SW]), w);
            if (en[c] && a != 0) begin
                et = 1'b1;
                mcnt[c] = (mcnt[c] + 1) % (1 << CW);
            end
        end
        for (int c = 0; c < N; c++) begin
            prv[0][c] = chip_word(data, c, 8);
            prv[1][c] = chip_word(data, c, 16);
            prv[2][c] = chip_word(data, c, 32);
            ec[c*CW +: CW] = CW'(mcnt[c]);
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, cnt, trig, ec, et);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        chk("R9", cnt, trig, '0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R1: placement per rate; chip 2 hit at each width
        en = '1;
        rate = 2'd0; data = '0; data[2*8 + 3] = 1'b1; step("R1");
        data = '0; step("R1");
        rate = 2'd1; data = '0; data[2*16 + 15] = 1'b1; step("R1");
        rate = 2'd2; data = '0; data[2*32 + 31] = 1'b1; step("R1");
        rate = 2'd3; data = '0; data[5*8] = 1'b1; step("R1");
        data = '0; step("R1");

        // R2: slip 1 carries top bit of previous word into the next cycle
        rate = 2'd0; slip = '0; slip[0 +: SW] = 5'd1; en = 6'b000001;
        data = '0; data[7] = 1'b1; step("R2");
        data = '0; step("R2");
        step("R2");
        // R3: slip 9 at 8-bit width acts as 1
        slip[0 +: SW] = 5'd9;
        data = '0; data[7] = 1'b1; step("R3");
        data = '0; step("R3");

        // R4: disabled chip with data
        slip = '0; en = 6'b111011;
        data = '0; data[2*8 +: 8] = 8'hFF; step("R4");
        en = '0; data = '1; step("R4");
        step("R4");

        // R6: back-to-back hits
        en = '1; data = '0; data[0] = 1'b1;
        for (int k = 0; k < 4; k++) step("R6");
        data = '0; step("R6");

        // R8: drive chip 0 past the counter wrap
        en = 6'b000001; data = '0; data[0] = 1'b1;
        for (int k = 0; k < 300; k++) step("R8");
        data = '0; step("R8");

        // R5 / R7: constrained random
        for (int k = 0; k < 3000; k++) begin
            rate = 2'($urandom % 4);
            en   = N'($urandom);
            data = '0;
            for (int b = 0; b < 3; b++)
                if ($urandom % 3 == 0) data[$urandom % (N*32)] = 1'b1;
            for (int c = 0; c < N; c++) slip[c*SW +: SW] = SW'($urandom);
            step((k % 2 == 0) ? "R5" : "R7");
        end

        // R9: reset mid-run clears everything
        data = '1; en = '1; step("R7");
        do_reset();
        data = '0; slip = '0; slip[0 +: SW] = 5'd1; en = 6'b000001; rate = 2'd0;
        step("R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule